// File: doc/BRIEF.md
# No-Turnaround Pipelined Burst SRAM

This block is a synthesizable, cycle-accurate model of a pipelined burst synchronous SRAM. Write data trails its command by the same two clocks that read data trails a read command. A controller can therefore issue reads and writes in any order on consecutive cycles, and the shared data bus never sits idle to turn around. Each command cycle either loads a new access or continues the current burst. A load takes an address, three chip selects and a read/write flag. A continue steps a 2-bit burst counter through the low address bits, in interleaved or linear order.

The bidirectional data bus is split into an input word, an output word and a drive flag. A top-level pad, or a bench, combines them into a tri-state bus. A clock hold input freezes every pipeline stage. Byte lanes can be written on their own through active-low lane enables. These enables are taken with the command cycle, not with the data. A read that hits a write whose data is still in flight returns the new bytes.

Top module: `ntd_sram`

## Requirements
- R1: A load with `cont_i`=0, all selects active and `is_read_i`=1 is a read. Its data is on `dout_o` with `bus_drive_o`=1 in the cycle after the next enabled edge. The controller samples it on the second enabled edge after the command.
- R2: A load with `is_read_i`=0 is a write. The array takes its data from `din_i` on the second enabled edge after the command.
- R3: With `cont_i`=1, the device ignores `addr_i`, the three selects and `is_read_i`. The cycle repeats the access type (read, write or deselect) of the most recent load.
- R4: The burst counter spans only address bits [1:0]. The upper bits stay at the load address, and the fifth access of a burst returns to the start address.
- R5: With `interleave_i`=1, the low two bits of the n-th access are start XOR n. With `interleave_i`=0, they are (start + n) mod 4.
- R6: A load deselects the device, so its data slot is undriven and performs no access, when `sel_a_n_i`=1, `sel_c_n_i`=1 or `sel_b_i`=0.
- R7: A continue that follows a deselect, or follows reset, is a further deselect. It performs no access and leaves the bus undriven.
- R8: `lane_wr_n_i[i]`=0 enables byte lane i, data bits [8i+7:8i]. The lanes are sampled in the command or continue cycle. A write with all four lanes high is an abort, and the array stays unchanged.
- R9: With `hold_i`=1, no stage advances and no write happens. A read slot stays driven with unchanged data, and a write slot stays undriven.
- R10: `bus_drive_o` is 1 only when `out_en_n_i`=0 and the current data slot is a read. It is 0 in write slots whatever `out_en_n_i` is.
- R11: A read of an address whose write data arrives on the same edge that the read enters its data slot returns the new bytes in the enabled lanes and the old bytes in the others.
- R12: A synchronous reset (`rst`=1) empties the pipeline, so `bus_drive_o` is 0 while reset is held and afterwards until a read reaches its data slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W (6) | Word address, used on load cycles |
| sel_a_n_i | input | 1 | Chip select, active low |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_n_i | input | 1 | Chip select, active low |
| cont_i | input | 1 | 1 = continue burst, 0 = load new access |
| is_read_i | input | 1 | 1 = read, 0 = write, used on load cycles |
| lane_wr_n_i | input | LANES (4) | Per-byte write enables, active low |
| hold_i | input | 1 | 1 = freeze the whole pipeline |
| out_en_n_i | input | 1 | Asynchronous output enable, active low |
| interleave_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| din_i | input | DATA_W (32) | Write data from the bus |
| dout_o | output | DATA_W (32) | Read data to the bus |
| bus_drive_o | output | 1 | Bus drive flag for dout_o |

## Verification
Reads and writes are driven back to back in mixed order, so that a wrong latency on either path shows up as stale or shifted data. Bursts run in both orders from unaligned start addresses and past the fourth access, which separates XOR from add and exposes a missing wrap. Continue cycles carry junk addresses, selects and direction flags, and each chip select deselects on its own, which shows whether those inputs are wrongly obeyed. Partial, full and empty lane masks, reads right behind writes to the same word, stalls in read and write slots, and output-enable toggles each isolate one datapath path.

// File: rtl/ntd_sram_pkg.sv
package ntd_sram_pkg;

    // Geometry of the modelled array
    localparam int ADDR_W  = 6;
    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int BURST_W = 2;
    localparam int DATA_W  = LANES * LANE_W;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // One access travelling down the command pipeline
    typedef struct packed {
        op_e                op;
        logic [ADDR_W-1:0]  addr;
        logic [LANES-1:0]   be;
    } slot_t;

    // Low address bits of the n-th access of a burst
    function automatic logic [BURST_W-1:0] burst_lo(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] cnt,
        input logic               interleave
    );
        return interleave ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/ntd_burst_seq.sv
module ntd_burst_seq
    import ntd_sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_i,
    input  logic              cont_i,
    input  logic              is_read_i,
    input  logic              sel_a_n_i,
    input  logic              sel_b_i,
    input  logic              sel_c_n_i,
    input  logic              interleave_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  lane_wr_n_i,
    output slot_t             cmd_o
);

    op_e                kind_q;
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_n;
    logic               dsel;

    always_comb begin
        dsel     = sel_a_n_i | sel_c_n_i | ~sel_b_i;
        cmd_o.be = ~lane_wr_n_i;
        if (cont_i) begin
            cnt_n      = cnt_q + 1'b1;
            cmd_o.op   = kind_q;
            cmd_o.addr = {base_q[ADDR_W-1:BURST_W],
                          burst_lo(base_q[BURST_W-1:0], cnt_n, interleave_i)};
        end else begin
            cnt_n      = '0;
            cmd_o.op   = dsel ? OP_NONE : (is_read_i ? OP_READ : OP_WRITE);
            cmd_o.addr = addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= OP_NONE;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (!hold_i) begin
            cnt_q <= cnt_n;
            if (!cont_i) begin
                kind_q <= cmd_o.op;
                base_q <= addr_i;
            end
        end
    end

    // After three steps the next continue lands on the start address again
    assert_burst_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (cont_i && cnt_q == '1) |-> (cmd_o.addr == base_q));

endmodule

// File: rtl/ntd_slot_pipe.sv
module ntd_slot_pipe
    import ntd_sram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold_i,
    input  slot_t cmd_i,
    output slot_t s1_o,
    output slot_t s2_o
);

    localparam slot_t IDLE_SLOT = '{op: OP_NONE, addr: '0, be: '0};

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_o <= IDLE_SLOT;
            s2_o <= IDLE_SLOT;
        end else if (!hold_i) begin
            s1_o <= cmd_i;
            s2_o <= s1_o;
        end
    end

    assert_slot_latency_R1: assert property (@(posedge clk) disable iff (rst)
        !hold_i |=> (s2_o == $past(s1_o)));

    assert_hold_freezes_R9: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> ($stable(s1_o) && $stable(s2_o)));

    assert_reset_empty_R12: assert property (@(posedge clk)
        rst |=> (s1_o.op == OP_NONE && s2_o.op == OP_NONE));

endmodule

// File: rtl/ntd_store.sv
module ntd_store
    import ntd_sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_i,
    input  op_e               rd_op_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  slot_t             wr_slot_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_raw;
    logic [DATA_W-1:0] rd_fwd;
    logic              hit;

    assign rd_raw = mem[rd_addr_i];
    assign hit    = (wr_slot_i.op == OP_WRITE) && (wr_slot_i.addr == rd_addr_i);

    // Forward bytes arriving on this edge to a read entering its data slot
    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign rd_fwd[l*LANE_W +: LANE_W] = (hit && wr_slot_i.be[l])
                                          ? din_i[l*LANE_W +: LANE_W]
                                          : rd_raw[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (!hold_i) begin
            if (wr_slot_i.op == OP_WRITE) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wr_slot_i.be[l]) begin
                        mem[wr_slot_i.addr][l*LANE_W +: LANE_W] <= din_i[l*LANE_W +: LANE_W];
                    end
                end
            end
            if (rd_op_i == OP_READ) begin
                rd_data_o <= rd_fwd;
            end
        end
    end

    assert_hold_keeps_data_R9: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> $stable(rd_data_o));

endmodule

// File: rtl/ntd_sram.sv
module ntd_sram
    import ntd_sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sel_a_n_i,
    input  logic              sel_b_i,
    input  logic              sel_c_n_i,
    input  logic              cont_i,
    input  logic              is_read_i,
    input  logic [LANES-1:0]  lane_wr_n_i,
    input  logic              hold_i,
    input  logic              out_en_n_i,
    input  logic              interleave_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              bus_drive_o
);

    slot_t cmd;
    slot_t s1;
    slot_t s2;

    ntd_burst_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .hold_i       (hold_i),
        .cont_i       (cont_i),
        .is_read_i    (is_read_i),
        .sel_a_n_i    (sel_a_n_i),
        .sel_b_i      (sel_b_i),
        .sel_c_n_i    (sel_c_n_i),
        .interleave_i (interleave_i),
        .addr_i       (addr_i),
        .lane_wr_n_i  (lane_wr_n_i),
        .cmd_o        (cmd)
    );

    ntd_slot_pipe u_pipe (
        .clk    (clk),
        .rst    (rst),
        .hold_i (hold_i),
        .cmd_i  (cmd),
        .s1_o   (s1),
        .s2_o   (s2)
    );

    ntd_store u_store (
        .clk       (clk),
        .rst       (rst),
        .hold_i    (hold_i),
        .rd_op_i   (s1.op),
        .rd_addr_i (s1.addr),
        .wr_slot_i (s2),
        .din_i     (din_i),
        .rd_data_o (dout_o)
    );

    assign bus_drive_o = (s2.op == OP_READ) && !out_en_n_i;

    assert_burst_keeps_op_R3: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && cont_i) |=> (s1.op == $past(s1.op)));

    assert_deselect_load_R6: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && !cont_i && (sel_a_n_i || sel_c_n_i || !sel_b_i))
        |=> (s1.op == OP_NONE));

endmodule

// File: tb/ntd_sram_tb_top.sv
module ntd_sram_tb_top;
    import ntd_sram_pkg::*;

    localparam int CLK_P = 10;

    typedef struct {
        bit                en;
        logic [DATA_W-1:0] data;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              sel_a_n_i = 1'b1;
    logic              sel_b_i = 1'b0;
    logic              sel_c_n_i = 1'b1;
    logic              cont_i = 1'b1;
    logic              is_read_i = 1'b1;
    logic [LANES-1:0]  lane_wr_n_i = '1;
    logic              hold_i = 1'b0;
    logic              out_en_n_i = 1'b0;
    logic              interleave_i = 1'b1;
    logic [DATA_W-1:0] din_i = '0;
    logic [DATA_W-1:0] dout_o;
    logic              bus_drive_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit ord_next = 1'b1;
    bit done = 1'b0;

    exp_t sbq[$];

    // Reference state built from the requirements
    int                m1_op = 0, m2_op = 0, bk_op = 0;
    logic [ADDR_W-1:0] m1_addr = '0, m2_addr = '0, bk_base = '0;
    logic [LANES-1:0]  m1_be = '0, m2_be = '0;
    logic [1:0]        bk_cnt = '0;
    logic [DATA_W-1:0] m2_data = '0;
    logic [DATA_W-1:0] mem_m [DEPTH];

    always #(CLK_P/2) clk = ~clk;

    ntd_sram dut_i (
        .clk          (clk),
        .rst          (rst),
        .addr_i       (addr_i),
        .sel_a_n_i    (sel_a_n_i),
        .sel_b_i      (sel_b_i),
        .sel_c_n_i    (sel_c_n_i),
        .cont_i       (cont_i),
        .is_read_i    (is_read_i),
        .lane_wr_n_i  (lane_wr_n_i),
        .hold_i       (hold_i),
        .out_en_n_i   (out_en_n_i),
        .interleave_i (interleave_i),
        .din_i        (din_i),
        .dout_o       (dout_o),
        .bus_drive_o  (bus_drive_o)
    );

    function automatic logic [DATA_W-1:0] pat(input int k);
        logic [7:0] b = 8'(k);
        return {b ^ 8'h5a, b + 8'h40, ~b, b};
    endfunction

    task automatic step(input bit c, input bit rd, input bit an, input bit b, input bit cn,
                        input logic [ADDR_W-1:0] a, input logic [LANES-1:0] wn,
                        input bit h, input bit oen, input string tag);
        exp_t              e;
        int                nop;
        logic [ADDR_W-1:0] naddr;
        logic [1:0]        lo;
        @(negedge clk);
        cont_i = c; is_read_i = rd; sel_a_n_i = an; sel_b_i = b; sel_c_n_i = cn;
        addr_i = a; lane_wr_n_i = wn; hold_i = h; out_en_n_i = oen;
        interleave_i = ord_next;
        din_i = pat(cyc);
        cyc++;
        if (!h) begin
            if (c) begin
                bk_cnt = bk_cnt + 2'd1;
                lo = interleave_i ? (bk_base[1:0] ^ bk_cnt) : (bk_base[1:0] + bk_cnt);
                naddr = {bk_base[ADDR_W-1:2], lo};
                nop = bk_op;
            end else begin
                nop = (an || cn || !b) ? 0 : (rd ? 1 : 2);
                naddr = a; bk_op = nop; bk_base = a; bk_cnt = 2'd0;
            end
            if (m2_op == 2) begin
                for (int l = 0; l < LANES; l++) begin
                    if (m2_be[l]) mem_m[m2_addr][l*LANE_W +: LANE_W] = din_i[l*LANE_W +: LANE_W];
                end
            end
            if (m1_op == 1) m2_data = mem_m[m1_addr];
            m2_op = m1_op; m2_addr = m1_addr; m2_be = m1_be;
            m1_op = nop; m1_addr = naddr; m1_be = ~wn;
        end
        e.en = (m2_op == 1) && !oen;
        e.data = m2_data;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] wn, input string t);
        step(0, 0, 0, 1, 0, a, wn, 0, 0, t);
    endtask
    task automatic rd(input logic [ADDR_W-1:0] a, input string t);
        step(0, 1, 0, 1, 0, a, '1, 0, 0, t);
    endtask
    task automatic go(input string t);
        step(1, 1, 1, 0, 1, 6'h2a, '0, 0, 0, t);
    endtask
    task automatic go_lanes(input logic [LANES-1:0] wn, input string t);
        step(1, 0, 0, 1, 0, 6'h3f, wn, 0, 0, t);
    endtask
    task automatic stall(input string t);
        step(0, 0, 0, 1, 0, 6'h09, '0, 1, 0, t);
    endtask
    task automatic quiet(input int n, input string t);
        for (int i = 0; i < n; i++) step(0, 1, 1, 1, 0, '0, '1, 0, 0, t);
    endtask

    // Monitor: compares each expected item after the edge it describes
    always @(posedge clk) begin
        exp_t e;
        #(CLK_P/4);
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            n_cmp++;
            if (bus_drive_o !== e.en || (e.en && dout_o !== e.data)) begin
                n_bad++;
                $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                         e.tag, bus_drive_o, dout_o, e.en, e.data);
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++;  // R12: no drive while reset is held
        if (bus_drive_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R12: drive=%0b expected drive=0", bus_drive_o);
        end
        @(negedge clk);
        rst = 1'b0;

        // R7: continue straight after reset is a deselect continue
        step(1, 1, 0, 1, 0, 6'h05, '0, 0, 0, "R7");
        quiet(2, "R12");

        // R1/R2: plain write then read
        wr(6'h05, 4'b0000, "R2");
        quiet(2, "R2");
        rd(6'h05, "R1");
        quiet(3, "R1");

        // R11: read right behind a write to the same word, full then partial lanes
        wr(6'h06, 4'b0000, "R11");
        rd(6'h06, "R11");
        wr(6'h06, 4'b1010, "R11");
        rd(6'h06, "R11");
        quiet(3, "R11");

        // R1/R2: alternating reads and writes with no gap
        wr(6'h07, 4'b0000, "R2");
        rd(6'h05, "R1");
        wr(6'h08, 4'b0000, "R2");
        rd(6'h07, "R1");
        rd(6'h08, "R1");
        quiet(3, "R1");

        // R5: interleaved write burst from 18, interleaved then linear reads from 17
        ord_next = 1'b1;
        wr(6'h12, 4'b0000, "R5");
        go_lanes(4'b0000, "R5"); go_lanes(4'b0000, "R5"); go_lanes(4'b0000, "R5");
        quiet(2, "R5");
        rd(6'h11, "R5"); go("R5"); go("R5"); go("R5");
        quiet(1, "R5");
        ord_next = 1'b0;
        rd(6'h11, "R5"); go("R5"); go("R5"); go("R5");
        quiet(3, "R5");

        // R3: continue cycles carry junk address, selects and direction
        wr(6'h28, 4'b0000, "R3");
        step(1, 1, 1, 0, 1, 6'h01, 4'b0000, 0, 0, "R3");
        step(1, 1, 0, 1, 0, 6'h02, 4'b0000, 0, 0, "R3");
        step(1, 1, 1, 1, 1, 6'h03, 4'b0000, 0, 0, "R3");
        quiet(2, "R3");
        rd(6'h28, "R3"); go("R3"); go("R3"); go("R3");
        quiet(3, "R3");

        // R4: five-access linear write burst from 33 wraps onto 33
        wr(6'h21, 4'b0000, "R4");
        go_lanes(4'b0000, "R4"); go_lanes(4'b0000, "R4");
        go_lanes(4'b0000, "R4"); go_lanes(4'b0000, "R4");
        quiet(2, "R4");
        rd(6'h21, "R4"); go("R4"); go("R4"); go("R4"); go("R4");
        quiet(3, "R4");

        // R6/R7: each select alone deselects, continues stay deselected
        step(0, 1, 1, 1, 0, 6'h05, '1, 0, 0, "R6");
        go("R7");
        step(0, 1, 0, 0, 0, 6'h05, '1, 0, 0, "R6");
        go("R7");
        step(0, 1, 0, 1, 1, 6'h05, '1, 0, 0, "R6");
        go("R7"); go("R7");
        step(0, 0, 0, 0, 0, 6'h05, 4'b0000, 0, 0, "R6");
        quiet(2, "R6");
        rd(6'h05, "R6");
        quiet(3, "R6");

        // R8: write abort, then partial lanes 0 and 3
        wr(6'h05, 4'b1111, "R8");
        quiet(2, "R8");
        rd(6'h05, "R8");
        quiet(2, "R8");
        wr(6'h05, 4'b0110, "R8");
        quiet(2, "R8");
        rd(6'h05, "R8");
        quiet(3, "R8");

        // R9: stall inside a read burst and inside a write data slot
        rd(6'h28, "R9"); go("R9"); go("R9");
        stall("R9"); stall("R9"); stall("R9");
        go("R9");
        quiet(2, "R9");
        wr(6'h2c, 4'b0000, "R9");
        quiet(1, "R9");
        stall("R9"); stall("R9");
        quiet(2, "R9");
        rd(6'h2c, "R9");
        quiet(3, "R9");

        // R10: output enable high blanks a read slot; write slot ignores it low
        rd(6'h06, "R10");
        step(0, 1, 1, 1, 0, '0, '1, 0, 1, "R10");
        step(0, 1, 1, 1, 0, '0, '1, 0, 0, "R10");
        wr(6'h30, 4'b0000, "R10");
        quiet(3, "R10");

        while (sbq.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule